// File: doc/BRIEF.md
# Internal RAM Window Decoder

This block places a 32-Kbyte on-chip RAM inside a 1-Mbyte bus address space. Software writes a small base register that holds a window-enable bit, a show-read bit and five base bits. The five base bits are compared with bus address bits 19..15, so the window can sit on any 32-Kbyte boundary, including base zero over the vector area at 00000h. For each bus cycle the block asserts an internal-RAM select. It also raises a flag that steers read data from the RAM instead of the external bus, and an enable that lets the external bus take part in the transfer.

Two debug modes come from strap pins that are sampled only while reset is held. A low disable strap keeps the RAM out of use, so every access that hits the window goes to the external bus. A low show-read strap, or the show-read register bit, copies internal read data onto the multiplexed address/data bus during the data phases. When the window and an external chip select hit the same cycle, both are active. Reads come from the RAM, writes go to both devices, and the block flags the overlap. It flags it a second time when that external select is not set up for zero wait states with external ready ignored.

Top module: `imem_window_dec`

## Requirements
- R1: While rst_n is low the base register clears, so cfg_rdata reads 0 after reset and no address selects the internal RAM until the enable bit is written.
- R2: An access is a cycle with bus_rd or bus_wr high and at least one bus_be bit set. int_sel is high for an access exactly when the enable bit is set and bus_addr[19:15] equals the base field. Base 0 covers 00000h..07FFFh and 08000h falls outside.
- R3: The base register is written by cfg_we. The bit layout is cfg_wdata[4:0] = base, [5] = enable, [6] = show-read bit. It reads back unchanged on cfg_rdata and holds its value while cfg_we is low.
- R4: If strap_ramoff_n is low while reset is held, int_sel and rdata_from_int stay low for window hits. Those accesses assert ext_xfer_en, and no show-read data is driven.
- R5: Show-read is active when strap_show_n was low during reset or the show-read register bit is set. With the strap active, clearing the register bit leaves show-read on.
- R6: bus_phase encodes t1=0, t2=1, t3=2, t4=3. In t1 every access drives ad_out = bus_addr[15:0] with ad_oe high. For an internal read with show-read active, t2 drives the address and t3 and t4 drive ram_rdata. In every other case ad_oe is low in t2..t4.
- R7: A show-read drives all 16 bits of ram_rdata whatever bus_be holds.
- R8: rdata_from_int is high for an internal read. An internal read keeps ext_xfer_en low, and a read outside the window raises it.
- R9: Every write access raises ext_xfer_en, and a write that hits the window also raises int_sel, so it reaches both devices.
- R10: overlap is high when int_sel and any ext_cs bit are high in the same cycle.
- R11: overlap_bad is high when int_sel is high together with an ext_cs bit whose ext_zws bit is low (that select is not set to zero wait states with ready ignored).
- R12: The straps are sampled only during reset; changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_ramoff_n | input | 1 | Active-low internal RAM disable strap |
| strap_show_n | input | 1 | Active-low show-read strap |
| cfg_we | input | 1 | Base register write strobe |
| cfg_wdata | input | 7 | Base register write value |
| cfg_rdata | output | 7 | Base register contents |
| bus_addr | input | 20 | Bus address |
| bus_rd | input | 1 | Read cycle |
| bus_wr | input | 1 | Write cycle |
| bus_be | input | 2 | Byte enables |
| bus_phase | input | 2 | Current bus phase t1..t4 |
| ext_cs | input | 6 | External chip selects active this cycle |
| ext_zws | input | 6 | Per select: zero wait states and ready ignored |
| ram_rdata | input | 16 | Read data from the internal RAM |
| int_sel | output | 1 | Internal RAM select |
| rdata_from_int | output | 1 | Read data taken from the internal RAM |
| ext_xfer_en | output | 1 | External bus takes part in the transfer |
| ad_oe | output | 1 | Multiplexed bus output enable |
| ad_out | output | 16 | Multiplexed bus address/data value |
| overlap | output | 1 | Internal and external selects both active |
| overlap_bad | output | 1 | Overlap with a select that has the wrong wait setup |

## Verification
Every decode output is a combinational function of the current bus inputs and the few registered bits of base and strap state. A corrupt base, enable or strap bit therefore shows at the ports on the very next access. It appears as a wrong int_sel or ext_xfer_en, or as show data in t3 where the bus should float, and cfg_rdata shows a corrupt register one cycle after the write. The bench uses reads on both sides of the window edges and accesses with no byte enabled. It repeats reset with each strap to expose a latched mode that is missing or stuck.

// File: rtl/imw_pkg.sv
package imw_pkg;

    typedef enum logic [1:0] {
        PH_T1 = 2'd0,
        PH_T2 = 2'd1,
        PH_T3 = 2'd2,
        PH_T4 = 2'd3
    } bus_phase_e;

    typedef struct packed {
        logic acc;
        logic sel;
        logic rd_int;
        logic xfer;
        logic ovl;
        logic bad;
    } dec_t;

endpackage

// File: rtl/imw_cfg_regs.sv
module imw_cfg_regs #(
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ramoff_n,
    input  logic              strap_show_n,
    input  logic              cfg_we,
    input  logic [BASE_W+1:0] cfg_wdata,
    output logic [BASE_W+1:0] cfg_rdata,
    output logic [BASE_W-1:0] base,
    output logic              win_en,
    output logic              show_act,
    output logic              ram_off
);
    localparam int EN_BIT   = BASE_W;
    localparam int SHOW_BIT = BASE_W + 1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              en;
        logic              show_bit;
        logic              off_strap;
        logic              show_strap;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d            = '0;
            st_d.off_strap  = ~strap_ramoff_n;
            st_d.show_strap = ~strap_show_n;
        end else if (cfg_we) begin
            st_d.base     = cfg_wdata[BASE_W-1:0];
            st_d.en       = cfg_wdata[EN_BIT];
            st_d.show_bit = cfg_wdata[SHOW_BIT];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_rdata = {st_q.show_bit, st_q.en, st_q.base};
    assign base      = st_q.base;
    assign win_en    = st_q.en;
    assign show_act  = st_q.show_strap | st_q.show_bit;
    assign ram_off   = st_q.off_strap;

endmodule

// File: rtl/imw_match.sv
module imw_match
    import imw_pkg::*;
#(
    parameter int BASE_W = 5,
    parameter int BE_W   = 2,
    parameter int N_EXT  = 6
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BASE_W-1:0] base,
    input  logic              win_en,
    input  logic              ram_off,
    input  logic [N_EXT-1:0]  ext_cs,
    input  logic [N_EXT-1:0]  ext_zws,
    output dec_t              dec
);
    logic [BASE_W-1:0] bit_eq;
    logic [N_EXT-1:0]  cs_bad;
    logic              hit;

    for (genvar i = 0; i < BASE_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(addr_hi[i] ^ base[i]);
    end

    for (genvar j = 0; j < N_EXT; j++) begin : g_cs
        assign cs_bad[j] = ext_cs[j] & ~ext_zws[j];
    end

    always_comb begin
        hit        = win_en & (&bit_eq);
        dec.acc    = (bus_rd | bus_wr) & (|bus_be);
        dec.sel    = dec.acc & hit & ~ram_off;
        dec.rd_int = dec.sel & bus_rd;
        dec.xfer   = dec.acc & (bus_wr | ~dec.sel);
        dec.ovl    = dec.sel & (|ext_cs);
        dec.bad    = dec.sel & (|cs_bad);
    end

endmodule

// File: rtl/imw_ad_mux.sv
module imw_ad_mux
    import imw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        bus_phase,
    input  logic              acc,
    input  logic              show_rd,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out
);
    bus_phase_e ph;

    always_comb begin
        ph     = bus_phase_e'(bus_phase);
        ad_oe  = 1'b0;
        ad_out = '0;
        unique case (ph)
            PH_T1: begin
                ad_oe  = acc;
                ad_out = acc ? addr_lo : '0;
            end
            PH_T2: begin
                ad_oe  = show_rd;
                ad_out = show_rd ? addr_lo : '0;
            end
            PH_T3, PH_T4: begin
                ad_oe  = show_rd;
                ad_out = show_rd ? ram_rdata : '0;
            end
            default: begin
                ad_oe  = 1'b0;
                ad_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/imem_window_dec.sv
module imem_window_dec
    import imw_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WIN_W  = 15,
    parameter int DATA_W = 16,
    parameter int N_EXT  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_ramoff_n,
    input  logic                      strap_show_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-WIN_W+1:0]   cfg_wdata,
    output logic [ADDR_W-WIN_W+1:0]   cfg_rdata,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [DATA_W/8-1:0]       bus_be,
    input  logic [1:0]                bus_phase,
    input  logic [N_EXT-1:0]          ext_cs,
    input  logic [N_EXT-1:0]          ext_zws,
    input  logic [DATA_W-1:0]         ram_rdata,
    output logic                      int_sel,
    output logic                      rdata_from_int,
    output logic                      ext_xfer_en,
    output logic                      ad_oe,
    output logic [DATA_W-1:0]         ad_out,
    output logic                      overlap,
    output logic                      overlap_bad
);
    localparam int BASE_W = ADDR_W - WIN_W;
    localparam int BE_W   = DATA_W / 8;

    logic [BASE_W-1:0] base;
    logic              win_en;
    logic              show_act;
    logic              ram_off;
    dec_t              dec;

    imw_cfg_regs #(.BASE_W(BASE_W)) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_ramoff_n (strap_ramoff_n),
        .strap_show_n   (strap_show_n),
        .cfg_we         (cfg_we),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .base           (base),
        .win_en         (win_en),
        .show_act       (show_act),
        .ram_off        (ram_off)
    );

    imw_match #(.BASE_W(BASE_W), .BE_W(BE_W), .N_EXT(N_EXT)) u_match (
        .addr_hi (bus_addr[ADDR_W-1:WIN_W]),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .bus_be  (bus_be),
        .base    (base),
        .win_en  (win_en),
        .ram_off (ram_off),
        .ext_cs  (ext_cs),
        .ext_zws (ext_zws),
        .dec     (dec)
    );

    imw_ad_mux #(.DATA_W(DATA_W)) u_ad (
        .bus_phase (bus_phase),
        .acc       (dec.acc),
        .show_rd   (dec.rd_int & show_act),
        .addr_lo   (bus_addr[DATA_W-1:0]),
        .ram_rdata (ram_rdata),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out)
    );

    assign int_sel        = dec.sel;
    assign rdata_from_int = dec.rd_int;
    assign ext_xfer_en    = dec.xfer;
    assign overlap        = dec.ovl;
    assign overlap_bad    = dec.bad;

endmodule

// File: rtl/imw_checker.sv
module imw_checker #(
    parameter int CFG_W  = 7,
    parameter int BE_W   = 2,
    parameter int N_EXT  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [BE_W-1:0]  bus_be,
    input logic [1:0]       bus_phase,
    input logic [N_EXT-1:0] ext_cs,
    input logic             int_sel,
    input logic             rdata_from_int,
    input logic             ext_xfer_en,
    input logic             ad_oe,
    input logic             overlap,
    input logic             overlap_bad
);
    assert_sel_is_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> ((bus_rd || bus_wr) && (|bus_be)));

    assert_cfg_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    assert_late_bus_only_show_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && bus_phase != 2'd0) |-> rdata_from_int);

    assert_int_read_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_from_int |-> (int_sel && !ext_xfer_en));

    assert_write_external_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (|bus_be)) |-> ext_xfer_en);

    assert_overlap_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |-> (int_sel && (|ext_cs)));

    assert_bad_is_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_bad |-> overlap);

endmodule

bind imem_window_dec imw_checker #(
    .CFG_W (ADDR_W - WIN_W + 2),
    .BE_W  (DATA_W / 8),
    .N_EXT (N_EXT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_rdata      (cfg_rdata),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .bus_be         (bus_be),
    .bus_phase      (bus_phase),
    .ext_cs         (ext_cs),
    .int_sel        (int_sel),
    .rdata_from_int (rdata_from_int),
    .ext_xfer_en    (ext_xfer_en),
    .ad_oe          (ad_oe),
    .overlap        (overlap),
    .overlap_bad    (overlap_bad)
);

// File: tb/imem_window_dec_tb.sv
module imem_window_dec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strap_ramoff_n, strap_show_n;
    logic        cfg_we;
    logic [6:0]  cfg_wdata, cfg_rdata;
    logic [19:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [1:0]  bus_be, bus_phase;
    logic [5:0]  ext_cs, ext_zws;
    logic [15:0] ram_rdata;
    logic        int_sel, rdata_from_int, ext_xfer_en, ad_oe, overlap, overlap_bad;
    logic [15:0] ad_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imem_window_dec u_dut (
        .clk(clk), .rst_n(rst_n), .strap_ramoff_n(strap_ramoff_n), .strap_show_n(strap_show_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_phase(bus_phase), .ext_cs(ext_cs), .ext_zws(ext_zws), .ram_rdata(ram_rdata),
        .int_sel(int_sel), .rdata_from_int(rdata_from_int), .ext_xfer_en(ext_xfer_en),
        .ad_oe(ad_oe), .ad_out(ad_out), .overlap(overlap), .overlap_bad(overlap_bad)
    );

    typedef struct packed {
        logic [19:0] a;
        logic        rd;
        logic        wr;
        logic [1:0]  be;
        logic [1:0]  ph;
        logic [5:0]  cs;
        logic [5:0]  zws;
        logic [15:0] rdat;
        logic        isel;
        logic        rint;
        logic        xfer;
        logic        oe;
        logic [15:0] ad;
        logic        ovl;
        logic        bad;
    } vec_t;

    // window base 3 (18000h..1FFFFh), enabled, show-read off
    localparam vec_t VECS [NV] = '{
        '{20'h18004, 1'b1, 1'b0, 2'b11, 2'd0, 6'h00, 6'h00, 16'hBEEF, 1'b1, 1'b1, 1'b0, 1'b1, 16'h8004, 1'b0, 1'b0},
        '{20'h18004, 1'b1, 1'b0, 2'b11, 2'd1, 6'h00, 6'h00, 16'hBEEF, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
        '{20'h18004, 1'b1, 1'b0, 2'b11, 2'd2, 6'h00, 6'h00, 16'hBEEF, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
        '{20'h20004, 1'b1, 1'b0, 2'b11, 2'd0, 6'h00, 6'h00, 16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0004, 1'b0, 1'b0},
        '{20'h20004, 1'b1, 1'b0, 2'b11, 2'd2, 6'h00, 6'h00, 16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},
        '{20'h1FFFE, 1'b0, 1'b1, 2'b11, 2'd0, 6'h00, 6'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFE, 1'b0, 1'b0},
        '{20'h18010, 1'b0, 1'b1, 2'b01, 2'd1, 6'h01, 6'h01, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},
        '{20'h18020, 1'b1, 1'b0, 2'b11, 2'd2, 6'h04, 6'h00, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1},
        '{20'h17FFF, 1'b1, 1'b0, 2'b10, 2'd0, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h7FFF, 1'b0, 1'b0},
        '{20'h20000, 1'b1, 1'b0, 2'b11, 2'd0, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0},
        '{20'h18008, 1'b1, 1'b0, 2'b00, 2'd0, 6'h01, 6'h00, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
        '{20'h18008, 1'b0, 1'b0, 2'b11, 2'd0, 6'h00, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
        '{20'h40000, 1'b1, 1'b0, 2'b11, 2'd2, 6'h02, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] outs();
        return {int_sel, rdata_from_int, ext_xfer_en, ad_oe, ad_out, overlap, overlap_bad};
    endfunction

    task automatic do_reset(input logic off_n, input logic show_n);
        @(negedge clk);
        rst_n = 1'b0; strap_ramoff_n = off_n; strap_show_n = show_n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; strap_ramoff_n = 1'b1; strap_show_n = 1'b1;
    endtask

    task automatic wr_cfg(input logic [6:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic drive(input logic [19:0] a, input logic rd, input logic wr,
                         input logic [1:0] be, input logic [1:0] ph, input logic [15:0] rdat);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_be = be; bus_phase = ph;
        ext_cs = '0; ext_zws = '0; ram_rdata = rdat;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; strap_ramoff_n = 1'b1; strap_show_n = 1'b1;
        cfg_we = 1'b0; cfg_wdata = '0;
        bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_be = '0; bus_phase = '0;
        ext_cs = '0; ext_zws = '0; ram_rdata = '0;

        // R1: reset state
        do_reset(1'b1, 1'b1);
        drive(20'h00000, 1'b1, 1'b0, 2'b11, 2'd0, 16'h0);
        check("R1 cfg_rdata after reset", 32'(cfg_rdata), 32'h0);
        check("R1 no select before enable", 32'(int_sel), 32'h0);

        // R3: write and read back
        wr_cfg(7'h23);
        #1;
        check("R3 readback", 32'(cfg_rdata), 32'h23);

        // vector table: R2 R6 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr = VECS[i].a; bus_rd = VECS[i].rd; bus_wr = VECS[i].wr;
            bus_be = VECS[i].be; bus_phase = VECS[i].ph; ext_cs = VECS[i].cs;
            ext_zws = VECS[i].zws; ram_rdata = VECS[i].rdat;
            #1;
            check($sformatf("R2/R6/R8/R9/R10/R11 vector %0d", i), 32'(outs()),
                  32'({VECS[i].isel, VECS[i].rint, VECS[i].xfer, VECS[i].oe,
                       VECS[i].ad, VECS[i].ovl, VECS[i].bad}));
        end

        // R5 R6: show-read via register bit
        wr_cfg(7'h63);
        #1;
        check("R3 readback show bit", 32'(cfg_rdata), 32'h63);
        drive(20'h18ABC, 1'b1, 1'b0, 2'b11, 2'd0, 16'hCAFE);
        check("R6 show t1 address", 32'({ad_oe, ad_out}), 32'h1_8ABC);
        drive(20'h18ABC, 1'b1, 1'b0, 2'b11, 2'd1, 16'hCAFE);
        check("R6 show t2 address", 32'({ad_oe, ad_out}), 32'h1_8ABC);
        drive(20'h18ABC, 1'b1, 1'b0, 2'b11, 2'd2, 16'hCAFE);
        check("R5 show t3 data", 32'({ad_oe, ad_out}), 32'h1_CAFE);
        drive(20'h18ABC, 1'b1, 1'b0, 2'b11, 2'd3, 16'hCAFE);
        check("R6 show t4 data", 32'({ad_oe, ad_out}), 32'h1_CAFE);
        drive(20'h18ABD, 1'b1, 1'b0, 2'b01, 2'd2, 16'hA55A);
        check("R7 byte show full word", 32'({ad_oe, ad_out}), 32'h1_A55A);
        drive(20'h18ABC, 1'b0, 1'b1, 2'b11, 2'd2, 16'hCAFE);
        check("R6 write no show", 32'(ad_oe), 32'h0);
        drive(20'h28ABC, 1'b1, 1'b0, 2'b11, 2'd2, 16'hCAFE);
        check("R6 external read floats", 32'(ad_oe), 32'h0);

        // R2: base zero over vector area
        wr_cfg(7'h20);
        drive(20'h00000, 1'b1, 1'b0, 2'b11, 2'd0, 16'h0);
        check("R2 base0 low end", 32'(int_sel), 32'h1);
        drive(20'h07FFF, 1'b1, 1'b0, 2'b11, 2'd0, 16'h0);
        check("R2 base0 high end", 32'(int_sel), 32'h1);
        drive(20'h08000, 1'b1, 1'b0, 2'b11, 2'd0, 16'h0);
        check("R2 base0 past end", 32'(int_sel), 32'h0);
        wr_cfg(7'h03);
        drive(20'h18000, 1'b1, 1'b0, 2'b11, 2'd0, 16'h0);
        check("R2 enable clear", 32'(int_sel), 32'h0);

        // R4: disable strap
        do_reset(1'b0, 1'b1);
        wr_cfg(7'h63);
        drive(20'h18000, 1'b1, 1'b0, 2'b11, 2'd0, 16'h0);
        check("R4 disabled read", 32'({int_sel, rdata_from_int, ext_xfer_en}), 32'h1);
        drive(20'h18000, 1'b1, 1'b0, 2'b11, 2'd2, 16'h7777);
        check("R4 disabled no show", 32'(ad_oe), 32'h0);

        // R5: show strap overrides cleared bit
        do_reset(1'b1, 1'b0);
        wr_cfg(7'h23);
        drive(20'h19000, 1'b1, 1'b0, 2'b11, 2'd3, 16'h1357);
        check("R5 strap show", 32'({ad_oe, ad_out}), 32'h1_1357);

        // R12: straps after reset ignored
        do_reset(1'b1, 1'b1);
        wr_cfg(7'h23);
        @(negedge clk);
        strap_ramoff_n = 1'b0; strap_show_n = 1'b0;
        repeat (2) @(negedge clk);
        drive(20'h18000, 1'b1, 1'b0, 2'b11, 2'd2, 16'h2468);
        check("R12 late straps ignored", 32'({int_sel, ad_oe}), 32'h2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule